// File: doc/BRIEF.md
# Byte-Granular Write Merger for a Word-Only SRAM

This block sits between a requester that writes 1, 2, 4 or 8 bytes at any byte address and a single-port synchronous SRAM. The SRAM takes only whole-word writes and addresses whole words. A write that covers every byte of one memory word is stored directly. A write that covers only some bytes of a word is handled in three steps: the block reads the word, replaces the selected bytes and writes the word back. A write whose bytes span two adjacent words repeats that sequence for each word, lower word first.

Reads are passed through. The block reads the addressed word and returns it unmodified when it signals completion. Requests use a valid/ready handshake and only one request is in flight at a time. The block drops ready when it accepts a request and raises it again after the one-cycle done pulse.

Top module: `rmw_write_ctrl`

## Requirements
- R1: The memory word address is the byte address shifted right by log2(WORD_BYTES), so byte address 0x04E addresses word 9 with byte offset 6. The first word touched by any request is that word.
- R2: A write with req_size=3 (8 bytes) at a byte address whose offset within the word is 0 performs exactly one memory write and no memory read. done is high in the 2nd cycle after the accepting clock edge.
- R3: A write that stays inside one word but does not cover all of it performs one read of that word, then one write to the same word address in the next cycle. done is high in the 3rd cycle after acceptance. Bytes outside the request keep their old value.
- R4: Byte order is little-endian. req_size encodes 2^req_size bytes (0:1, 1:2, 2:4, 3:8). Data byte k (bits 8k+7..8k) is stored at byte address req_addr+k, and addresses wrap at the top of the address space.
- R5: A write whose bytes extend past the end of its first word performs read and write of word w, then read and write of word w+1 (modulo the word count). This is two reads and two writes in total, and done is high in the 5th cycle after acceptance.
- R6: A read request (req_write=0) performs one memory read and no write. done is high in the 2nd cycle after acceptance, with rdata equal to the full addressed word.
- R7: req_ready is high only in idle and low from the accepting edge through the done cycle. done lasts one cycle. Address and data inputs are latched at acceptance, so changes to them while busy have no effect.
- R8: During and after reset, req_ready is high, done is low and mem_en is low. A reset in the middle of a request returns the block to idle.
- R9: mem_we is only asserted together with mem_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Byte count as 2^req_size |
| req_wdata | input | 8*WORD_BYTES | Write data, byte 0 at lowest address |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8*WORD_BYTES | Read word, valid with done on a read |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W-log2(WORD_BYTES) | SRAM word address |
| mem_wdata | output | 8*WORD_BYTES | SRAM write word |
| mem_rdata | input | 8*WORD_BYTES | SRAM read word, one cycle after a read |

## Verification
The properties assume that the SRAM returns read data exactly one cycle after a read and that a request never holds more bytes than one memory word. They also assume that the requester looks at req_valid only while req_ready is high. The stimulus meets each assumption. The bench models a one-cycle-latency SRAM. Every request uses a size of 8 bytes or less against a 64-bit word. The bench waits for done before it offers the next request, and while the block is busy it deliberately puts junk on the address and data inputs to show that they are ignored.

// File: rtl/rmw_write_ctrl.sv
module rmw_write_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int WORD_BYTES = 8,
  localparam int WORD_W    = WORD_BYTES * 8,
  localparam int OFF_W     = $clog2(WORD_BYTES),
  localparam int WADDR_W   = ADDR_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               done,
  output logic [WORD_W-1:0]  rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0]  mem_wdata,
  input  logic [WORD_W-1:0]  mem_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_WR1, S_RD2, S_WR2, S_DONE} state_t;

  state_t                    st;
  logic [2*WORD_W-1:0]       data_q;
  logic [2*WORD_BYTES-1:0]   mask_q;
  logic [WADDR_W-1:0]        wa_q;
  logic                      wr_q;

  logic [OFF_W-1:0]          off;
  logic [2*WORD_BYTES-1:0]   ones_n, lanes;
  logic [2*WORD_W-1:0]       wide_d;
  logic                      hi;
  logic [WORD_BYTES-1:0]     sel_mask;
  logic [WORD_W-1:0]         sel_data;

  assign off    = req_addr[OFF_W-1:0];
  assign wide_d = {{WORD_W{1'b0}}, req_wdata} << {off, 3'b000};
  assign lanes  = ones_n << off;

  always_comb begin
    ones_n = '0;
    for (int k = 0; k < 2*WORD_BYTES; k++)
      ones_n[k] = (k < (1 << req_size));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      data_q <= '0;
      mask_q <= '0;
      wa_q   <= '0;
      wr_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          data_q <= wide_d;
          mask_q <= lanes;
          wa_q   <= req_addr[ADDR_W-1:OFF_W];
          wr_q   <= req_write;
          st     <= (req_write && (&lanes[WORD_BYTES-1:0])) ? S_WR1 : S_RD1;
        end
        S_RD1:   st <= wr_q ? S_WR1 : S_DONE;
        S_WR1:   st <= (|mask_q[2*WORD_BYTES-1:WORD_BYTES]) ? S_RD2 : S_DONE;
        S_RD2:   st <= S_WR2;
        S_WR2:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign hi        = (st == S_RD2) || (st == S_WR2);
  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_DONE);
  assign rdata     = mem_rdata;
  assign mem_en    = (st == S_RD1) || (st == S_WR1) || hi;
  assign mem_we    = (st == S_WR1) || (st == S_WR2);
  assign mem_addr  = hi ? wa_q + WADDR_W'(1) : wa_q;
  assign sel_mask  = hi ? mask_q[2*WORD_BYTES-1:WORD_BYTES] : mask_q[WORD_BYTES-1:0];
  assign sel_data  = hi ? data_q[2*WORD_W-1:WORD_W] : data_q[WORD_W-1:0];

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign mem_wdata[8*b +: 8] = sel_mask[b] ? sel_data[8*b +: 8] : mem_rdata[8*b +: 8];
  end

endmodule

// File: rtl/rmw_write_ctrl_chk.sv
module rmw_write_ctrl_chk #(
  parameter int WADDR_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic               done,
  input logic               mem_en,
  input logic               mem_we,
  input logic [WADDR_W-1:0] mem_addr
);

  AST_WE_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);  // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);  // R7

  AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);  // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_en);  // R8

  AST_WRITE_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> (!mem_we || mem_addr == $past(mem_addr)));  // R3

  AST_NEXT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (!mem_en || (!mem_we && mem_addr == $past(mem_addr) + 1'b1)));  // R5

  AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write) |=> (mem_en && !mem_we));  // R6

endmodule

bind rmw_write_ctrl rmw_write_ctrl_chk #(.WADDR_W(WADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .done(done), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr)
);

// File: tb/rmw_write_ctrl_tb.sv
`timescale 1ns/1ps
module rmw_write_ctrl_tb;
  localparam int ADDR_W  = 12;
  localparam int WB      = 8;
  localparam int WADDR_W = ADDR_W - 3;
  localparam int NW      = 1 << WADDR_W;
  localparam int NV      = 10;

  // {write, size, addr, data, exp_cycles, exp_reads, exp_writes}
  localparam logic [86:0] VEC [NV] = '{
    {1'b1, 2'd3, 12'h040, 64'h1122334455667788, 4'd2, 2'd0, 2'd1},  // R2 full aligned
    {1'b1, 2'd0, 12'h043, 64'h00000000000000AB, 4'd3, 2'd1, 2'd1},  // R3 byte
    {1'b1, 2'd1, 12'h04A, 64'h000000000000BEEF, 4'd3, 2'd1, 2'd1},  // R3 half
    {1'b1, 2'd2, 12'h04E, 64'h00000000CAFEF00D, 4'd5, 2'd2, 2'd2},  // R5 word off 6
    {1'b1, 2'd3, 12'h05D, 64'h0F1E2D3C4B5A6978, 4'd5, 2'd2, 2'd2},  // R5 dword off 5
    {1'b1, 2'd2, 12'h064, 64'h00000000DEADBEEF, 4'd3, 2'd1, 2'd1},  // R3 upper half
    {1'b0, 2'd0, 12'h04E, 64'h0,                4'd2, 2'd1, 2'd0},  // R6 read
    {1'b1, 2'd1, 12'h1FF, 64'h0000000000007755, 4'd5, 2'd2, 2'd2},  // R5 off 7
    {1'b1, 2'd3, 12'hFFC, 64'hA1A2A3A4A5A6A7A8, 4'd5, 2'd2, 2'd2},  // R4 wrap to word 0
    {1'b0, 2'd3, 12'h000, 64'h0,                4'd2, 2'd1, 2'd0}   // R6 read word 0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, done, mem_en, mem_we;
  logic [63:0] rdata, mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic [WADDR_W-1:0] mem_addr;

  logic [63:0] mem [NW];
  logic [63:0] ref_mem [NW];
  int n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;

  always #4 clk = ~clk;

  rmw_write_ctrl #(.ADDR_W(ADDR_W), .WORD_BYTES(WB)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [63:0] pat(int i);
    return {32'h5EED0000 | 32'(i), 32'hC0DE0000 ^ 32'(i * 3)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem[i] <= pat(i);
    end else if (mem_en) begin
      if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      else begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic wr, input logic [1:0] sz, input logic [ADDR_W-1:0] a,
                         input logic [63:0] d, input int ecyc, input int erd, input int ewr);
    int cyc;
    bit busy_ready;
    int w0, w1, ba;
    logic [63:0] exp_rd;
    w0 = int'(a) >> 3;
    w1 = (w0 + 1) % NW;
    exp_rd = ref_mem[w0];
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    chk(req_ready == 1'b1, "R7 ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d; req_size = ~sz;
    cyc = 1; busy_ready = 1'b0;
    while (!done && cyc < 20) begin
      if (req_ready) busy_ready = 1'b1;
      @(negedge clk);
      cyc++;
    end
    chk(!busy_ready && !req_ready, "R7 ready low while busy", 64'(busy_ready), 64'd0);
    chk(cyc == ecyc, wr ? "R2/R3/R5 done latency" : "R6 read latency", 64'(cyc), 64'(ecyc));
    chk(rd_cnt == erd, "R2/R3/R5/R6 read count", 64'(rd_cnt), 64'(erd));
    chk(wr_cnt == ewr, "R2/R3/R5/R6 write count", 64'(wr_cnt), 64'(ewr));
    if (!wr) chk(rdata == exp_rd, "R6 rdata word (R1 address)", rdata, exp_rd);
    else
      for (int k = 0; k < (1 << sz); k++) begin
        ba = (int'(a) + k) % (1 << ADDR_W);
        ref_mem[ba >> 3][(ba & 7)*8 +: 8] = d[8*k +: 8];
      end
    chk(mem[w0] == ref_mem[w0], "R1/R3/R4 first word", mem[w0], ref_mem[w0]);
    chk(mem[w1] == ref_mem[w1], "R4/R5 next word", mem[w1], ref_mem[w1]);
    req_addr = '0; req_wdata = '0; req_size = '0;
    @(negedge clk);
    chk(req_ready && !done, "R7 idle after done pulse", {62'd0, req_ready, done}, 64'd2);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) ref_mem[i] = pat(i);
    repeat (3) @(negedge clk);
    chk(req_ready && !done && !mem_en, "R8 reset state", {61'd0, req_ready, done, mem_en}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !mem_en, "R8 idle after reset", {61'd0, req_ready, done, mem_en}, 64'd4);

    for (int v = 0; v < NV; v++)
      run_req(VEC[v][86], VEC[v][85:84], VEC[v][83:72], VEC[v][71:8],
              int'(VEC[v][7:4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]));

    // R3: last byte of a word stays inside it
    run_req(1'b1, 2'd0, 12'h2A7, 64'h3C, 3, 1, 1);
    // R3: two bytes ending exactly at word end
    run_req(1'b1, 2'd1, 12'h2AE, 64'h9911, 3, 1, 1);
    // R5: four bytes at offset 5 cross
    run_req(1'b1, 2'd2, 12'h2B5, 64'h76543210, 5, 2, 2);
    // R2: second full aligned write elsewhere
    run_req(1'b1, 2'd3, 12'h3F8, 64'hFEDCBA9876543210, 2, 0, 1);

    // R8: reset in the middle of a request
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_addr = 12'h123; req_wdata = 64'h77;
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_en && !done, "R8 abort to idle", {61'd0, req_ready, mem_en, done}, 64'd4);
    for (int i = 0; i < NW; i++) ref_mem[i] = pat(i);
    rst_n = 1'b1;
    @(negedge clk);
    run_req(1'b1, 2'd0, 12'h123, 64'h77, 3, 1, 1);

    begin
      int bad = 0;
      for (int i = 0; i < NW; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R4 whole memory image", 64'(bad), 64'd0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule